// File: doc/BRIEF.md
# Strobe-Sampled DDR Serial Byte Receiver

This block receives a single-speed inter-chip serial stream made of one single-ended data line and a forwarded strobe line. Every transition of the strobe, rising or falling, marks one data bit. The sampling point comes only from the strobe; the block does no phase recovery from any preamble and negotiates no speed. Captured bits are packed least-significant first into bytes, which go to a packet layer above that expects the byte stream of a USB high-speed link.

Both lines are brought into a local reference clock domain through synchronizer chains of equal depth, so data and strobe stay aligned. A transition seen at the end of the chain captures the data level seen in the same stage. After eight captures the block shows the byte on its byte bus for one reference cycle, together with a valid pulse. If the strobe stays quiet for a set number of reference cycles, the block raises a line-idle flag and drops any bits it has collected toward an unfinished byte.

Top module: `ddr_strobe_rx`

## Requirements
- R1: While reset is held and directly after it, `rx_valid` is 0 and `line_idle` is 1.
- R2: Each change of `strobe_in` in either direction captures exactly one bit: the level `data_in` held when that change was sampled. The strobe must hold each level for at least one reference cycle, and data must be stable when the strobe changes.
- R3: Each group of eight captured bits produces exactly one byte on `rx_byte`. No byte is produced for fewer than eight captures.
- R4: The first captured bit of a byte goes to `rx_byte[0]` and the eighth goes to `rx_byte[7]`. Within one strobe period, the bit taken at the rising edge therefore sits one position below the bit taken at the following falling edge.
- R5: `rx_valid` is high for exactly one reference cycle per byte, and `rx_byte` is defined only in that cycle.
- R6: `line_idle` rises once `IDLE_CYCLES` reference cycles have passed since the cycle in which the last strobe change was registered (SYNC_STAGES+1 cycles after it reached the input pin), with no further change.
- R7: When `line_idle` rises, the bits collected toward an unfinished byte are discarded. The next strobe change starts a new byte at bit 0.
- R8: A strobe change clears `line_idle` in the same cycle in which it is captured. `line_idle` is never high while `rx_valid` is high.
- R9: `rx_valid` rises SYNC_STAGES+1 reference cycles after the strobe change that carries the eighth bit appears at the input (3 cycles with the default of 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| strobe_in | input | 1 | Forwarded strobe; each transition marks one bit |
| data_in | input | 1 | Single-ended serial data line |
| rx_byte | output | 8 | Assembled byte, least-significant bit received first |
| rx_valid | output | 1 | One-cycle pulse marking a new byte on `rx_byte` |
| line_idle | output | 1 | High while the strobe has been quiet for the timeout |

## Verification
A wrong bit count inside the block shows at the ports as a byte that is early, late or shifted. The bench catches it at the first byte after the fault, because it checks the value of every byte and also the exact cycle of every `rx_valid` pulse. A wrong quiet-time counter shows as a `line_idle` edge in the wrong cycle, and the bench compares that flag against its own timing model on every clock. A leftover partial byte that should have been discarded shows up as a corrupt first byte after the idle period. The bench forces this case by sending five stray bits before a gap.

// File: rtl/ddr_strobe_rx.sv
`timescale 1ns/100ps
module ddr_strobe_rx #(
  parameter int IDLE_CYCLES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_in,
  input  logic       data_in,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       line_idle
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] IDLE_LIMIT = CW'(IDLE_CYCLES);

  logic [SYNC_STAGES-1:0] stb_sync;
  logic [SYNC_STAGES-1:0] dat_sync;
  logic                   stb_prev;
  logic                   stb_q;
  logic                   dat_q;
  logic                   strobe_edge;
  logic [2:0]             bit_cnt;
  logic [7:0]             shreg;
  logic [CW-1:0]          idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_sync <= '0;
      dat_sync <= '0;
      stb_prev <= 1'b0;
    end else begin
      stb_sync <= {stb_sync[SYNC_STAGES-2:0], strobe_in};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], data_in};
      stb_prev <= stb_q;
    end
  end

  assign stb_q       = stb_sync[SYNC_STAGES-1];
  assign dat_q       = dat_sync[SYNC_STAGES-1];
  assign strobe_edge = stb_q ^ stb_prev;
  assign line_idle   = (idle_cnt == IDLE_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (strobe_edge) begin
        shreg   <= {dat_q, shreg[7:1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_byte  <= {dat_q, shreg[7:1]};
          rx_valid <= 1'b1;
        end
      end else if (line_idle) begin
        bit_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      idle_cnt <= IDLE_LIMIT;
    else if (strobe_edge)
      idle_cnt <= '0;
    else if (!line_idle)
      idle_cnt <= idle_cnt + 1'b1;
  end
endmodule

// File: rtl/ddr_strobe_rx_chk.sv
`timescale 1ns/100ps
module ddr_strobe_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe_edge,
  input logic rx_valid,
  input logic line_idle
);
  logic [3:0] edge_cnt;
  logic [3:0] edge_base;

  assign edge_base = (rx_valid || line_idle) ? 4'd0 : edge_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      edge_cnt <= '0;
    else
      edge_cnt <= edge_base + {3'd0, strobe_edge};
  end

  p_eight_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> edge_cnt == 4'd8);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_edge_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_edge |=> !line_idle);

  p_idle_no_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> !rx_valid);

  p_wake_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_idle) |-> $past(strobe_edge));
endmodule

bind ddr_strobe_rx ddr_strobe_rx_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .strobe_edge(strobe_edge),
  .rx_valid(rx_valid),
  .line_idle(line_idle)
);

// File: tb/sim_ddr_strobe_rx.sv
`timescale 1ns/100ps
module sim_ddr_strobe_rx;
  localparam int LIMIT = 20;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_in = 1'b0;
  logic data_in = 1'b0;
  logic [7:0] rx_byte;
  logic rx_valid;
  logic line_idle;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int m_n = 0;
  logic [7:0] m_bits = '0;
  int last_k = -1000;
  int last_seen = 0;
  logic exp_idle = 1'b1;
  bit finished = 1'b0;
  int exp_byte[$];
  int exp_due[$];
  int tog_q[$];

  ddr_strobe_rx #(.IDLE_CYCLES(LIMIT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .data_in(data_in),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .line_idle(line_idle)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic model_bit(input logic b, input int k);
    if (k - last_k > LAT + LIMIT) m_n = 0;
    last_k = k;
    tog_q.push_back(k);
    m_bits = {b, m_bits[7:1]};
    m_n++;
    if (m_n == 8) begin
      exp_byte.push_back(int'(m_bits));
      exp_due.push_back(k + LAT);
      m_n = 0;
    end
  endtask

  task automatic send_bit(input logic b, input bit fast);
    if (fast) begin
      @(negedge clk);
      data_in = b;
      strobe_in = ~strobe_in;
      model_bit(b, cyc);
    end else begin
      @(negedge clk);
      data_in = b;
      @(negedge clk);
      strobe_in = ~strobe_in;
      model_bit(b, cyc);
      @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input bit fast);
    for (int i = 0; i < 8; i++) send_bit(v[i], fast);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      while (tog_q.size() > 0 && tog_q[0] + LAT == cyc) begin
        void'(tog_q.pop_front());
        exp_idle = 1'b0;
        last_seen = cyc;
      end
      if (!exp_idle && cyc - last_seen >= LIMIT) exp_idle = 1'b1;
      chk(line_idle == exp_idle, "R6 R8 line_idle", int'(line_idle), int'(exp_idle));
      if (rx_valid) begin
        if (exp_byte.size() == 0) begin
          chk(1'b0, "R3 R5 unexpected byte", int'(rx_byte), -1);
        end else begin
          int eb;
          int ed;
          eb = exp_byte.pop_front();
          ed = exp_due.pop_front();
          chk(int'(rx_byte) == eb, "R2 R4 byte value", int'(rx_byte), eb);
          chk(cyc == ed, "R9 byte latency", cyc, ed);
        end
      end else if (exp_due.size() > 0 && exp_due[0] < cyc) begin
        chk(1'b0, "R3 R9 missing byte", cyc, exp_due[0]);
        void'(exp_byte.pop_front());
        void'(exp_due.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    gap(4);
    chk(rx_valid == 1'b0, "R1 valid in reset", int'(rx_valid), 0);
    chk(line_idle == 1'b1, "R1 idle in reset", int'(line_idle), 1);
    rst_n = 1'b1;
    gap(2);
    chk(rx_valid == 1'b0, "R1 valid after reset", int'(rx_valid), 0);
    chk(line_idle == 1'b1, "R1 idle after reset", int'(line_idle), 1);

    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b0);
    send_byte(8'h00, 1'b0);
    send_byte(8'hFF, 1'b0);
    send_byte(8'h81, 1'b0);
    gap(LIMIT + 10);
    chk(exp_byte.size() == 0, "R3 slow stream drained", exp_byte.size(), 0);

    send_byte(8'h96, 1'b1);
    send_byte(8'h01, 1'b1);
    send_byte(8'h80, 1'b1);
    send_byte(8'h7E, 1'b1);
    gap(LIMIT + 10);
    chk(exp_byte.size() == 0, "R2 fast stream drained", exp_byte.size(), 0);

    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    gap(LIMIT + 10);
    chk(line_idle == 1'b1, "R7 idle after partial", int'(line_idle), 1);
    send_byte(8'h5E, 1'b0);
    send_byte(8'hC3, 1'b1);
    gap(LIMIT + 10);
    chk(exp_byte.size() == 0, "R7 partial discarded", exp_byte.size(), 0);

    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1);
    gap(LIMIT + 10);
    send_byte(8'h2B, 1'b1);
    gap(LIMIT + 10);
    chk(exp_byte.size() == 0, "R7 short burst discarded", exp_byte.size(), 0);
    chk(line_idle == 1'b1, "R6 idle at end", int'(line_idle), 1);
    finish_up();
  end
endmodule